// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a 32-bit integer processor core built as five stages in a row: fetch, decode, execute, memory access and write-back. A register sits between each pair of stages, so up to five instructions are in flight at once and one instruction can finish every cycle. The core runs register-to-register arithmetic, add-immediate, word load and store, two equality branches, and four jumps. Branches and jumps are decided in decode and have one delay slot, so no fetched instruction is ever thrown away.

The core has no hazard detection, forwarding or stall logic. The program must keep at least three instructions between a register write and any read of that register. Both memories are plain single-cycle ports. The core drives an address, and the word comes back combinationally in the same cycle. These ports have no valid/ready handshake and no back-pressure: every access completes in the cycle it is issued. Debug taps show the contents of the decode, execute-result and write-back stage registers.

The link value of a call is formed by the execute-stage adder as (PC+4)+4. No separate adder is used.

Top module: `pipe5_core`

## Requirements
- R1: Instruction fields sit at fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0], immediate [15:0], jump index [25:0]. Instructions retire in program order with no bubbles, one per cycle, including across branches and jumps. A result leaves write-back exactly four cycles after its instruction was fetched.
- R2: While rst_n is low, the fetch address is 0, every stage register holds zero (a no-op, with no memory write and no register write), and all registers read as zero.
- R3: With opcode 0, the function codes 0x20/0x21 (add), 0x22/0x23 (subtract), 0x24 (and), 0x25 (or), 0x26 (xor), 0x27 (nor), 0x2A (signed less-than), 0x2B (unsigned less-than), 0x00 (shift left), 0x02 (logical shift right) and 0x03 (arithmetic shift right) write their result to rd. Shifts use the value of rt and the shift-amount field.
- R4: Opcode 0x08 writes rs plus the sign-extended immediate to rt.
- R5: Opcode 0x23 loads the word at rs+sext(imm) into rt. Opcode 0x2B stores rt to that address. dmem_we or dmem_re is raised exactly two cycles after the instruction is visible on dbg_ifid_inst. The two are never raised together.
- R6: Opcode 0x04 branches when rs equals rt, and 0x05 branches when they differ. The equality test is done in decode. The target is the delay-slot address plus the sign-extended immediate shifted left by 2, so backward offsets work. The delay-slot instruction always executes.
- R7: Opcodes 0x02 and 0x03 jump to {delay-slot address[31:28], index, 2'b00} after the delay slot.
- R8: Function codes 0x08 and 0x09 (with opcode 0) jump to the value of rs after the delay slot.
- R9: Opcode 0x03 writes the instruction's own address + 8 to register 31. Function code 0x09 writes that value to rd.
- R10: Writes to register 0 are dropped, and register 0 always reads as 0.
- R11: When the instruction in decode is not a branch or jump, the next fetch address is the current one plus 4.
- R12: dbg_ifid_inst shows the word that was returned on imem_rdata in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word for imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address from the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_re | output | 1 | Load in progress |
| dmem_rdata | input | 32 | Data word for dmem_addr, same cycle |
| dbg_ifid_inst | output | 32 | Instruction held in the fetch/decode register |
| dbg_ifid_pc4 | output | 32 | Fetch address + 4 held with it |
| dbg_exmem_alu | output | 32 | ALU result held in the execute/memory register |
| dbg_wb_we | output | 1 | Write-back stage requests a register write |
| dbg_wb_dst | output | 5 | Write-back destination register |
| dbg_wb_data | output | 32 | Write-back value |

## Verification
The overlap that matters most is a branch or jump being resolved in decode while write-back is updating an unrelated register in the same cycle. The same overlap occurs with a call, whose link value goes down the pipe while the fetch is redirected. Directed blocks place branches, calls and returns directly behind arithmetic that writes other registers. A long random straight-line section keeps loads, stores and arithmetic overlapping in every stage. Each write-back result and each store is compared, in order and by cycle, against a trace from an instruction-level model with delay-slot semantics. Fixed end values then prove which paths were taken.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XW = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [2:0] {
    NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JIMM, NPC_JREG
  } npc_kind_e;

  typedef struct packed {
    logic reg_we;
    logic mem_to_reg;
  } wb_ctl_t;

  typedef struct packed {
    logic mem_we;
    logic mem_re;
  } mem_ctl_t;

  typedef struct packed {
    alu_op_e op;
    logic    b_imm;
    logic    link;
  } ex_ctl_t;

  typedef struct packed {
    logic [XW-1:0] inst;
    logic [XW-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    ex_ctl_t       ex;
    mem_ctl_t      mem;
    wb_ctl_t       wb;
    logic [XW-1:0] rs_val;
    logic [XW-1:0] rt_val;
    logic [XW-1:0] imm;
    logic [XW-1:0] pc4;
    logic [4:0]    dst;
    logic [4:0]    shamt;
  } idex_t;

  typedef struct packed {
    mem_ctl_t      mem;
    wb_ctl_t       wb;
    logic [XW-1:0] alu;
    logic [XW-1:0] st_data;
    logic [4:0]    dst;
  } exmem_t;

  typedef struct packed {
    wb_ctl_t       wb;
    logic [XW-1:0] ld_data;
    logic [XW-1:0] alu;
    logic [4:0]    dst;
  } memwb_t;

endpackage

// File: rtl/pipe5_pipereg.sv
module pipe5_pipereg #(
  parameter int             W       = 32,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic [4:0]  rt,
  input  logic [4:0]  rd,
  output ex_ctl_t     ex,
  output mem_ctl_t    mem,
  output wb_ctl_t     wb,
  output logic [4:0]  dst,
  output npc_kind_e   npc_kind
);
  always_comb begin
    ex       = '{op: ALU_ADD, b_imm: 1'b0, link: 1'b0};
    mem      = '0;
    wb       = '0;
    dst      = rd;
    npc_kind = NPC_SEQ;
    unique case (opcode)
      OP_RTYPE: begin
        wb.reg_we = 1'b1;
        unique case (funct)
          FN_ADD, FN_ADDU: ex.op = ALU_ADD;
          FN_SUB, FN_SUBU: ex.op = ALU_SUB;
          FN_AND:  ex.op = ALU_AND;
          FN_OR:   ex.op = ALU_OR;
          FN_XOR:  ex.op = ALU_XOR;
          FN_NOR:  ex.op = ALU_NOR;
          FN_SLT:  ex.op = ALU_SLT;
          FN_SLTU: ex.op = ALU_SLTU;
          FN_SLL:  ex.op = ALU_SLL;
          FN_SRL:  ex.op = ALU_SRL;
          FN_SRA:  ex.op = ALU_SRA;
          FN_JR: begin
            wb.reg_we = 1'b0;
            npc_kind  = NPC_JREG;
          end
          FN_JALR: begin
            ex.link  = 1'b1;
            npc_kind = NPC_JREG;
          end
          default: wb.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ex.b_imm  = 1'b1;
        wb.reg_we = 1'b1;
        dst       = rt;
      end
      OP_LW: begin
        ex.b_imm      = 1'b1;
        mem.mem_re    = 1'b1;
        wb.reg_we     = 1'b1;
        wb.mem_to_reg = 1'b1;
        dst           = rt;
      end
      OP_SW: begin
        ex.b_imm   = 1'b1;
        mem.mem_we = 1'b1;
      end
      OP_BEQ:  npc_kind = NPC_BEQ;
      OP_BNE:  npc_kind = NPC_BNE;
      OP_J:    npc_kind = NPC_JIMM;
      OP_JAL: begin
        npc_kind  = NPC_JIMM;
        ex.link   = 1'b1;
        wb.reg_we = 1'b1;
        dst       = 5'd31;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  y
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
      ALU_SLL:  y = b << shamt;
      ALU_SRL:  y = b >> shamt;
      ALU_SRA:  y = $unsigned($signed(b) >>> shamt);
      default:  y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREG     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic [31:0] dbg_ifid_inst,
  output logic [31:0] dbg_ifid_pc4,
  output logic [31:0] dbg_exmem_alu,
  output logic        dbg_wb_we,
  output logic [4:0]  dbg_wb_dst,
  output logic [31:0] dbg_wb_data
);
  localparam int IFID_W  = $bits(ifid_t);
  localparam int IDEX_W  = $bits(idex_t);
  localparam int EXMEM_W = $bits(exmem_t);
  localparam int MEMWB_W = $bits(memwb_t);

  // load enable of every stage register; held on in this version
  logic stage_en;
  assign stage_en = 1'b1;

  // ---------------- fetch ----------------
  logic [31:0] pc, pc_next, if_pc4;
  ifid_t ifid_d, ifid_q;

  pipe5_pipereg #(.W(32), .RST_VAL(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .en(stage_en), .d(pc_next), .q(pc));

  assign imem_addr = pc;
  assign if_pc4    = pc + 32'd4;
  assign ifid_d    = '{inst: imem_rdata, pc4: if_pc4};

  pipe5_pipereg #(.W(IFID_W)) u_ifid (
    .clk(clk), .rst_n(rst_n), .en(stage_en), .d(ifid_d), .q(ifid_q));

  // ---------------- decode ----------------
  logic [5:0]  id_op, id_fn;
  logic [4:0]  id_rs, id_rt, id_rd, id_sh, id_dst;
  logic [31:0] id_imm, id_rs_val, id_rt_val, id_br_tgt, id_j_tgt;
  logic        id_eq;
  ex_ctl_t     id_ex;
  mem_ctl_t    id_mem;
  wb_ctl_t     id_wb;
  npc_kind_e   id_npc;
  idex_t       idex_d, idex_q;

  assign id_op  = ifid_q.inst[31:26];
  assign id_rs  = ifid_q.inst[25:21];
  assign id_rt  = ifid_q.inst[20:16];
  assign id_rd  = ifid_q.inst[15:11];
  assign id_sh  = ifid_q.inst[10:6];
  assign id_fn  = ifid_q.inst[5:0];
  assign id_imm = {{16{ifid_q.inst[15]}}, ifid_q.inst[15:0]};

  pipe5_decode u_dec (
    .opcode(id_op), .funct(id_fn), .rt(id_rt), .rd(id_rd),
    .ex(id_ex), .mem(id_mem), .wb(id_wb), .dst(id_dst), .npc_kind(id_npc));

  // write-back side of the register file is driven from the last stage
  memwb_t      memwb_q;
  logic [31:0] wb_data;

  pipe5_regfile #(.NREG(NREG), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(memwb_q.wb.reg_we), .waddr(memwb_q.dst), .wdata(wb_data),
    .raddr_a(id_rs), .raddr_b(id_rt),
    .rdata_a(id_rs_val), .rdata_b(id_rt_val));

  // branch decision is made here, one cycle after fetch; the slot behind
  // the branch is already in fetch and always proceeds
  assign id_eq     = (id_rs_val == id_rt_val);
  assign id_br_tgt = ifid_q.pc4 + {id_imm[29:0], 2'b00};
  assign id_j_tgt  = {ifid_q.pc4[31:28], ifid_q.inst[25:0], 2'b00};

  always_comb begin
    unique case (id_npc)
      NPC_BEQ:  pc_next = id_eq  ? id_br_tgt : if_pc4;
      NPC_BNE:  pc_next = !id_eq ? id_br_tgt : if_pc4;
      NPC_JIMM: pc_next = id_j_tgt;
      NPC_JREG: pc_next = id_rs_val;
      default:  pc_next = if_pc4;
    endcase
  end

  assign idex_d = '{ex: id_ex, mem: id_mem, wb: id_wb,
                    rs_val: id_rs_val, rt_val: id_rt_val, imm: id_imm,
                    pc4: ifid_q.pc4, dst: id_dst, shamt: id_sh};

  pipe5_pipereg #(.W(IDEX_W)) u_idex (
    .clk(clk), .rst_n(rst_n), .en(stage_en), .d(idex_d), .q(idex_q));

  // ---------------- execute ----------------
  logic [31:0] ex_a, ex_b, ex_y;
  exmem_t      exmem_d, exmem_q;

  // link value: (address+4)+4 through the shared adder
  assign ex_a = idex_q.ex.link ? idex_q.pc4 : idex_q.rs_val;
  assign ex_b = idex_q.ex.link  ? 32'd4 :
                idex_q.ex.b_imm ? idex_q.imm : idex_q.rt_val;

  pipe5_alu #(.W(32)) u_alu (
    .op(idex_q.ex.op), .a(ex_a), .b(ex_b), .shamt(idex_q.shamt), .y(ex_y));

  assign exmem_d = '{mem: idex_q.mem, wb: idex_q.wb, alu: ex_y,
                     st_data: idex_q.rt_val, dst: idex_q.dst};

  pipe5_pipereg #(.W(EXMEM_W)) u_exmem (
    .clk(clk), .rst_n(rst_n), .en(stage_en), .d(exmem_d), .q(exmem_q));

  // ---------------- memory ----------------
  memwb_t memwb_d;

  assign dmem_addr  = exmem_q.alu;
  assign dmem_wdata = exmem_q.st_data;
  assign dmem_we    = exmem_q.mem.mem_we;
  assign dmem_re    = exmem_q.mem.mem_re;

  assign memwb_d = '{wb: exmem_q.wb, ld_data: dmem_rdata,
                     alu: exmem_q.alu, dst: exmem_q.dst};

  pipe5_pipereg #(.W(MEMWB_W)) u_memwb (
    .clk(clk), .rst_n(rst_n), .en(stage_en), .d(memwb_d), .q(memwb_q));

  // ---------------- write-back ----------------
  assign wb_data = memwb_q.wb.mem_to_reg ? memwb_q.ld_data : memwb_q.alu;

  assign dbg_ifid_inst = ifid_q.inst;
  assign dbg_ifid_pc4  = ifid_q.pc4;
  assign dbg_exmem_alu = exmem_q.alu;
  assign dbg_wb_we     = memwb_q.wb.reg_we;
  assign dbg_wb_dst    = memwb_q.dst;
  assign dbg_wb_data   = wb_data;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] dbg_ifid_inst,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        dbg_wb_we,
  input logic [4:0]  dbg_wb_dst,
  input logic [31:0] dbg_wb_data
);
  logic [5:0]  c_op, c_fn;
  logic        c_ctl;
  logic [31:0] c_boff;

  assign c_op   = dbg_ifid_inst[31:26];
  assign c_fn   = dbg_ifid_inst[5:0];
  assign c_ctl  = (c_op == 6'h02) || (c_op == 6'h03) || (c_op == 6'h04) ||
                  (c_op == 6'h05) ||
                  ((c_op == 6'h00) && ((c_fn == 6'h08) || (c_fn == 6'h09)));
  assign c_boff = {{14{dbg_ifid_inst[15]}}, dbg_ifid_inst[15:0], 2'b00};

  // R11
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ctl |=> imem_addr == $past(imem_addr) + 32'd4);

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'h02 || c_op == 6'h03) |=>
      imem_addr == {$past(imem_addr[31:28]), $past(dbg_ifid_inst[25:0]), 2'b00});

  // R6
  branch_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'h04 || c_op == 6'h05) |=>
      (imem_addr == $past(imem_addr) + 32'd4) ||
      (imem_addr == $past(imem_addr) + $past(c_boff)));

  // R9
  link_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'h03) |-> ##3
      (dbg_wb_we && dbg_wb_dst == 5'd31 && dbg_wb_data == $past(imem_addr, 3) + 32'd4));

  // R5
  store_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == 6'h2B) |-> ##2 dmem_we);

  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));
endmodule

bind pipe5_core pipe5_core_chk i_chk (.*);

// File: tb/test_pipe5_core.sv
module test_pipe5_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic [31:0] dbg_ifid_inst, dbg_ifid_pc4, dbg_exmem_alu, dbg_wb_data;
  logic        dbg_wb_we;
  logic [4:0]  dbg_wb_dst;

  always #4 clk = ~clk;  // 125 MHz

  pipe5_core i_pipe5_core (.*);

  logic [31:0] imem [512];
  logic [31:0] dmem [64];
  assign imem_rdata = imem[imem_addr[10:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  int total = 0, bad = 0;
  bit running = 0, done = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // ---------------- program builder ----------------
  int wp = 0;
  function automatic void emit(logic [31:0] w);
    imem[wp] = w;
    wp++;
  endfunction
  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int byte_addr);
    logic [31:0] a = 32'(byte_addr);
    return {6'(op), a[27:2]};
  endfunction

  // ---------------- instruction-level model ----------------
  logic [4:0]  ex_reg [1024];
  logic [31:0] ex_val [1024];
  int          ex_dyn [1024];
  int          ex_tag [1024];
  int          n_exp = 0;
  logic [31:0] st_a [512];
  logic [31:0] st_v [512];
  int          n_st = 0;

  function automatic string tag_name(int t);
    case (t)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic run_model();
    logic [31:0] r [32];
    logic [31:0] m [64];
    logic [31:0] pc = 0, npc = 4, nn, inst, a, b, imm, res;
    logic [5:0] op, fn;
    int rs, rt, rd, sh, dst, tg;
    bit wr;
    for (int i = 0; i < 32; i++) r[i] = 0;
    for (int i = 0; i < 64; i++) m[i] = dmem[i];
    for (int dyn = 0; dyn < 3000; dyn++) begin
      inst = imem[pc[10:2]];
      op = inst[31:26]; fn = inst[5:0];
      rs = inst[25:21]; rt = inst[20:16]; rd = inst[15:11]; sh = inst[10:6];
      imm = {{16{inst[15]}}, inst[15:0]};
      a = r[rs]; b = r[rt];
      nn = npc + 4; wr = 0; dst = 0; res = 0; tg = 3;
      case (op)
        6'h00: begin
          wr = 1; dst = rd;
          case (fn)
            6'h20, 6'h21: res = a + b;
            6'h22, 6'h23: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h26: res = a ^ b;
            6'h27: res = ~(a | b);
            6'h2A: res = ($signed(a) < $signed(b)) ? 1 : 0;
            6'h2B: res = (a < b) ? 1 : 0;
            6'h00: res = b << sh;
            6'h02: res = b >> sh;
            6'h03: res = $unsigned($signed(b) >>> sh);
            6'h08: begin wr = 0; nn = a; end
            6'h09: begin res = pc + 8; tg = 9; nn = a; end
            default: wr = 0;
          endcase
        end
        6'h08: begin wr = 1; dst = rt; res = a + imm; tg = 4; end
        6'h23: begin wr = 1; dst = rt; res = m[(a + imm) >> 2 & 63]; tg = 5; end
        6'h2B: begin
          m[((a + imm) >> 2) & 63] = b;
          st_a[n_st] = a + imm; st_v[n_st] = b; n_st++;
        end
        6'h04: if (a == b) nn = npc + (imm << 2);
        6'h05: if (a != b) nn = npc + (imm << 2);
        6'h02, 6'h03: begin
          nn = {npc[31:28], inst[25:0], 2'b00};
          if (op == 6'h03) begin wr = 1; dst = 31; res = pc + 8; tg = 9; end
        end
        default: ;
      endcase
      if (wr && dst != 0) begin
        r[dst] = res;
        ex_reg[n_exp] = 5'(dst); ex_val[n_exp] = res;
        ex_dyn[n_exp] = dyn; ex_tag[n_exp] = tg; n_exp++;
      end
      if (op == 6'h02 && nn == pc) break;
      pc = npc; npc = nn;
    end
  endtask

  // ---------------- monitors ----------------
  int cyc = 0, n_got = 0, n_st_got = 0, off = 0;
  logic [31:0] shadow [32];
  bit          shw [32];
  logic [31:0] prev_word;

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (cyc > 1)
        check(dbg_ifid_inst == prev_word, "R12", "ifid tap", dbg_ifid_inst, prev_word);
      prev_word = imem_rdata;
      if (dbg_wb_we && dbg_wb_dst != 0) begin
        if (n_got < n_exp) begin
          check(dbg_wb_dst == ex_reg[n_got], tag_name(ex_tag[n_got]), "wb dst",
                32'(dbg_wb_dst), 32'(ex_reg[n_got]));
          check(dbg_wb_data == ex_val[n_got], tag_name(ex_tag[n_got]), "wb data",
                dbg_wb_data, ex_val[n_got]);
          if (n_got == 0) off = cyc - ex_dyn[0];
          else check(cyc - ex_dyn[n_got] == off, "R1", "retire cycle",
                     32'(cyc - ex_dyn[n_got]), 32'(off));
        end else begin
          check(0, "R1", "extra write", 32'(dbg_wb_dst), 0);
        end
        shadow[dbg_wb_dst] = dbg_wb_data; shw[dbg_wb_dst] = 1;
        n_got++;
      end
      if (dmem_we) begin
        if (n_st_got < n_st) begin
          check(dmem_addr == st_a[n_st_got], "R5", "store addr", dmem_addr, st_a[n_st_got]);
          check(dmem_wdata == st_v[n_st_got], "R5", "store data", dmem_wdata, st_v[n_st_got]);
        end else check(0, "R5", "extra store", dmem_addr, 0);
        n_st_got++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 700);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main ----------------
  int recent [3];
  int lbl_j, lbl_jalr, lbl_end, lbl_loop;
  localparam int F_W = 400, G_W = 420;

  function automatic int pick_src();
    int s;
    do s = $urandom_range(0, 12);
    while (s == recent[0] || s == recent[1] || s == recent[2]);
    return s;
  endfunction
  function automatic void push_dst(int d);
    recent[2] = recent[1]; recent[1] = recent[0]; recent[0] = d;
  endfunction

  initial begin
    int fns [13] = '{'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h27, 'h2A, 'h2B, 'h00, 'h02, 'h03};
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) imem[i] = 32'h0;
    for (int i = 0; i < 64; i++) dmem[i] = $urandom;
    for (int i = 0; i < 32; i++) begin shadow[i] = 0; shw[i] = 0; end
    recent = '{-1, -1, -1};

    // random straight-line section, registers 1..12
    for (int i = 1; i <= 12; i++) begin
      emit(enc_i('h08, 0, i, $urandom_range(0, 65535))); push_dst(i);
    end
    for (int i = 0; i < 150; i++) begin
      int k = $urandom_range(0, 8);
      int d = $urandom_range(1, 12);
      if (k <= 4) begin
        int a = pick_src(); int b = pick_src();
        if ($urandom_range(0, 15) == 0) d = 0;
        emit(enc_r(fns[$urandom_range(0, 12)], a, b, d, $urandom_range(0, 31)));
        push_dst(d);
      end else if (k <= 6) begin
        emit(enc_i('h08, pick_src(), d, $urandom_range(0, 65535))); push_dst(d);
      end else if (k == 7) begin
        emit(enc_i('h23, 0, d, 4 * $urandom_range(0, 63))); push_dst(d);
      end else begin
        emit(enc_i('h2B, 0, pick_src(), 4 * $urandom_range(0, 63))); push_dst(-1);
      end
    end
    emit(0); emit(0); emit(0);

    // R10: write to register 0, then read it
    emit(enc_i('h08, 0, 0, 77)); emit(0); emit(0); emit(0);
    emit(enc_r('h20, 0, 0, 16, 0));
    // R6: taken beq skips one word after its slot
    emit(enc_i('h08, 0, 17, 9)); emit(enc_i('h08, 0, 18, 9));
    emit(0); emit(0); emit(0);
    emit(enc_i('h04, 17, 18, 2));
    emit(enc_i('h08, 0, 19, 1));
    emit(enc_i('h08, 0, 20, 2));
    emit(enc_i('h08, 0, 21, 3));
    // R6: not-taken bne falls through
    emit(enc_i('h05, 17, 18, 2));
    emit(enc_i('h08, 0, 22, 5));
    emit(enc_i('h08, 0, 23, 6));
    emit(enc_i('h08, 0, 24, 7));
    // R6: backward taken bne, three passes
    emit(enc_i('h08, 0, 25, 3)); emit(0); emit(0); emit(0);
    lbl_loop = wp;
    emit(enc_i('h08, 25, 25, -1));
    emit(enc_i('h08, 26, 26, 1));
    emit(0); emit(0);
    emit(enc_i('h05, 25, 0, -5));
    emit(0);
    // R7 R9: call with link into 31, return by jr (R8)
    lbl_j = wp;
    emit(enc_j('h03, F_W * 4));
    emit(enc_i('h08, 0, 27, 4));
    emit(enc_i('h08, 0, 28, 8));
    // R8 R9: register call with link into 13
    emit(enc_i('h08, 0, 30, G_W * 4)); emit(0); emit(0); emit(0);
    lbl_jalr = wp;
    emit(enc_r('h09, 30, 0, 13, 0));
    emit(enc_i('h08, 0, 15, 2));
    emit(enc_i('h08, 0, 14, 3));
    lbl_end = wp;
    emit(enc_j('h02, lbl_end * 4));
    emit(0);
    wp = F_W;
    emit(0); emit(0); emit(0);
    emit(enc_r('h08, 31, 0, 0, 0));
    emit(enc_i('h08, 0, 29, 1));
    wp = G_W;
    emit(0); emit(0); emit(0);
    emit(enc_r('h08, 13, 0, 0, 0));
    emit(0);

    run_model();

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(imem_addr == 0, "R2", "reset fetch addr", imem_addr, 0);
    check(dbg_ifid_inst == 0, "R2", "reset ifid", dbg_ifid_inst, 0);
    check(dbg_wb_we == 0, "R2", "reset wb we", 32'(dbg_wb_we), 0);
    check(dmem_we == 0, "R2", "reset dmem we", 32'(dmem_we), 0);
    rst_n = 1'b1;
    prev_word = imem_rdata;
    running = 1;
    repeat (700) @(negedge clk);
    running = 0;

    check(n_got == n_exp, "R1", "write count", 32'(n_got), 32'(n_exp));
    check(n_st_got == n_st, "R5", "store count", 32'(n_st_got), 32'(n_st));
    check(shw[16] && shadow[16] == 0, "R10", "r0 read back", shadow[16], 0);
    check(shadow[19] == 1, "R6", "beq delay slot", shadow[19], 1);
    check(!shw[20], "R6", "beq skipped word", 32'(shw[20]), 0);
    check(shadow[21] == 3, "R6", "beq target", shadow[21], 3);
    check(shadow[22] == 5 && shadow[23] == 6 && shadow[24] == 7, "R6", "bne fall-through",
          shadow[23], 6);
    check(shadow[25] == 0 && shadow[26] == 3, "R6 R2", "backward loop", shadow[26], 3);
    check(shadow[27] == 4 && shadow[28] == 8, "R7", "jal slot and return", shadow[28], 8);
    check(shadow[29] == 1, "R8", "jr delay slot", shadow[29], 1);
    check(shadow[31] == 32'(lbl_j * 4 + 8), "R9", "jal link", shadow[31], 32'(lbl_j * 4 + 8));
    check(shadow[13] == 32'(lbl_jalr * 4 + 8), "R9", "jalr link", shadow[13],
          32'(lbl_jalr * 4 + 8));
    check(shadow[14] == 3 && shadow[15] == 2, "R8", "jalr slot and return", shadow[14], 3);
    check(imem_addr == 32'(lbl_end * 4) || imem_addr == 32'(lbl_end * 4 + 4), "R11",
          "parked at end loop", imem_addr, 32'(lbl_end * 4));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule